// File: doc/BRIEF.md
# Oversampling Majority-Vote Serial Receiver

This block takes in asynchronous serial frames of ten bits: a low start bit, eight data bits sent least significant bit first, and a stop bit. It does not make its own timing. A separate sampling strobe arrives at sixteen times the bit rate, and the receiver only acts on cycles where that strobe is high. The serial line first passes through a two-stage synchronizer. Edge detection then compares the synchronized level at each strobe against the level at the previous strobe.

A high-to-low step on the line starts a frame. The sixteen-state bit-phase counter is restarted on that step, so its wrap points line up with the boundaries of the incoming bits. In each bit, the line is sampled at phases 7, 8 and 9, and the value seen at least twice is taken as the bit. If the first bit taken this way is high, the step was noise and the receiver goes back to waiting for a new edge.

A nine-bit shift register is preset to all ones when a frame starts. Each accepted bit enters on the right. When the start-bit zero reaches the leftmost position, the frame is complete. At that point the byte and the stop bit are captured and a sticky done flag is raised. The flag stays set until software-side logic pulses a clear.

Top module: `os_uart_rx`

## Requirements
- R1: Reset values: `rx_done` = 0, `rx_byte` = 0, `rx_stop` = 0, and the receiver is idle.
- R2: A frame starts only on a strobe cycle. The receiver must be idle with `rx_enable` = 1, the synchronized line must read 0, and the line must have read 1 at the previous strobe. That strobe counts as bit phase 0.
- R3: While the receiver is idle with `rx_enable` = 0, falling edges are ignored. No frame starts and `rx_done` stays 0.
- R4: Each bit is sampled at the strobes of phases 7, 8 and 9, and the 2-of-3 majority is taken as the bit. A single wrong sample inside each bit does not change the received byte.
- R5: If the majority value of the start bit is 1, the receiver returns to idle without raising `rx_done`. A valid frame that follows is still received correctly.
- R6: The second frame bit becomes `rx_byte[0]`, and so on up to the ninth frame bit, which becomes `rx_byte[7]`.
- R7: The tenth frame bit, 0 or 1, is captured in `rx_stop`. The frame completes whichever value it has.
- R8: Completion happens on the strobe 153 strobes after the start strobe, which is phase 9 of the tenth bit. `rx_byte` and `rx_stop` change only on that cycle, and `rx_done` rises only there.
- R9: `rx_done` stays at 1 until a `done_clr` pulse. It reads 0 one cycle after the pulse, except when a completion happens in the same cycle as the clear, in which case the completion wins.
- R10: Dropping `rx_enable` in the middle of a frame does not abort that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_enable | input | 1 | Allows new frames to start |
| done_clr | input | 1 | Pulse that clears `rx_done` |
| rx_byte | output | 8 | Last byte received |
| rx_stop | output | 1 | Stop bit of the last frame |
| rx_done | output | 1 | Sticky frame-complete flag |

## Verification
In the bench, the line changes on the falling clock edge just after a strobe, and strobes come every four cycles. The falling edge is therefore detected at the next strobe. The byte, the stop bit and the done flag are due exactly 154 strobes, or 616 cycles, after the line is driven low. The monitor measures this interval for every frame. A clear is expected to take effect one cycle after the pulse, and the monitor reads the flag on the next falling clock edge. Negative checks for noise starts and disabled reception wait more than a full frame time before sampling the flag.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic early;
        logic centre;
    } vote_hold_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/osr_sync.sv
module osr_sync #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= IDLE_LVL;
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{IDLE_LVL}};
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/osr_vote.sv
module osr_vote
    import os_rx_pkg::*;
#(
    parameter int unsigned PH_W = 4,
    parameter int unsigned MID  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [PH_W-1:0] phase,
    input  logic            din,
    output logic            bit_vld,
    output logic            bit_val
);
    localparam logic [PH_W-1:0] PH_A = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_B = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_C = PH_W'(MID + 1);

    vote_hold_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '{early: 1'b1, centre: 1'b1};
        end else if (tick) begin
            if (phase == PH_A) hold_q.early  <= din;
            if (phase == PH_B) hold_q.centre <= din;
        end
    end

    // third sample is the live value on the deciding strobe
    assign bit_vld = tick && (phase == PH_C);
    assign bit_val = maj3(hold_q.early, hold_q.centre, din);
endmodule

// File: rtl/osr_frame.sv
module osr_frame
    import os_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_enable,
    input  logic              fall,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic [PH_W-1:0]   phase,
    output logic              busy,
    output logic              done_evt,
    output logic [DATA_W-1:0] data,
    output logic              stop
);
    localparam int unsigned      SH_W      = DATA_W + 1;
    localparam logic [SH_W-1:0]  SH_PRESET = '1;

    rx_state_e         state_q;
    logic [PH_W-1:0]   phase_q;
    logic [SH_W-1:0]   shift_q;
    logic [DATA_W-1:0] data_q;
    logic              stop_q;
    logic [DATA_W-1:0] rev;

    logic start, decide, first_bit, frame_last, reject, finish;

    assign start      = (state_q == RX_IDLE) && rx_enable && fall;
    assign decide     = (state_q == RX_BUSY) && bit_vld;
    assign first_bit  = (shift_q == SH_PRESET);
    assign frame_last = !shift_q[SH_W-1];
    assign reject     = decide && first_bit && bit_val;
    assign finish     = decide && frame_last;

    // first-arrived bit sits highest in the shifter: reverse to LSB-first order
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_rev
            assign rev[g] = shift_q[DATA_W-1-g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            phase_q <= '0;
            shift_q <= SH_PRESET;
            data_q  <= '0;
            stop_q  <= 1'b0;
        end else if (start) begin
            // edge strobe is phase 0, so the next strobe sees phase 1
            state_q <= RX_BUSY;
            phase_q <= PH_W'(1);
            shift_q <= SH_PRESET;
        end else if ((state_q == RX_BUSY) && tick) begin
            phase_q <= phase_q + PH_W'(1);
            if (reject || finish) begin
                state_q <= RX_IDLE;
            end else if (decide) begin
                shift_q <= {shift_q[SH_W-2:0], bit_val};
            end
            if (finish) begin
                data_q <= rev;
                stop_q <= bit_val;
            end
        end
    end

    assign phase    = phase_q;
    assign busy     = (state_q == RX_BUSY);
    assign done_evt = finish;
    assign data     = data_q;
    assign stop     = stop_q;
endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OSR_LOG2    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SAMPLE_MID  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rx_in,
    input  logic              rx_enable,
    input  logic              done_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_stop,
    output logic              rx_done
);
    localparam int unsigned PH_W = OSR_LOG2;

    logic            rx_s;
    logic            last_q;
    logic            fall;
    logic [PH_W-1:0] phase;
    logic            busy;
    logic            stop_evt;
    logic            vote_vld;
    logic            vote_bit;
    logic            done_q;

    osr_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rx_s)
    );

    always_ff @(posedge clk) begin
        if (rst)         last_q <= 1'b1;
        else if (tick16) last_q <= rx_s;
    end

    assign fall = tick16 && last_q && !rx_s;

    osr_vote #(.PH_W(PH_W), .MID(SAMPLE_MID)) vote_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .phase   (phase),
        .din     (rx_s),
        .bit_vld (vote_vld),
        .bit_val (vote_bit)
    );

    osr_frame #(.DATA_W(DATA_W), .PH_W(PH_W)) frame_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rx_enable (rx_enable),
        .fall      (fall),
        .bit_vld   (vote_vld),
        .bit_val   (vote_bit),
        .phase     (phase),
        .busy      (busy),
        .done_evt  (stop_evt),
        .data      (rx_byte),
        .stop      (rx_stop)
    );

    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (stop_evt) done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    assign rx_done = done_q;
endmodule

// File: rtl/os_uart_rx_chk.sv
module os_uart_rx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick16,
    input logic              rx_enable,
    input logic              done_clr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_stop,
    input logic              rx_done,
    input logic              busy,
    input logic              stop_evt
);
    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick16));

    // R3
    idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rx_enable) |=> !busy);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_evt |=> ($stable(rx_byte) && $stable(rx_stop)));

    // R8
    done_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(stop_evt));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !done_clr) |=> rx_done);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_clr && !stop_evt) |=> !rx_done);
endmodule

bind os_uart_rx os_uart_rx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick16    (tick16),
    .rx_enable (rx_enable),
    .done_clr  (done_clr),
    .rx_byte   (rx_byte),
    .rx_stop   (rx_stop),
    .rx_done   (rx_done),
    .busy      (busy),
    .stop_evt  (stop_evt)
);

// File: tb/os_uart_rx_tb_top.sv
module os_uart_rx_tb_top;
    localparam int unsigned LATENCY = 616;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_enable = 1'b1;
    logic       done_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_stop;
    logic       rx_done;

    always #5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [1:0] tdiv = 2'd0;
    always @(negedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    os_uart_rx dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick16    (tick16),
        .rx_in     (rx_in),
        .rx_enable (rx_enable),
        .done_clr  (done_clr),
        .rx_byte   (rx_byte),
        .rx_stop   (rx_stop),
        .rx_done   (rx_done)
    );

    typedef struct {
        logic [7:0] b;
        logic       s;
        string      tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        cur;
    int          checks = 0;
    int          errors = 0;
    int unsigned start_cyc = 0;
    bit          auto_clr = 1'b1;
    bit          prev_done = 1'b0;
    bit          clr_pend = 1'b0;
    bit          mon_on = 1'b0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic next_tick();
        @(posedge clk iff tick16);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic s, input bit noisy,
                        input bit push, input string tag, input int drop_at,
                        input int false_len);
        if (push) exp_q.push_back('{b: b, s: s, tag: tag});
        next_tick();
        start_cyc = cyc;
        if (false_len > 0) begin
            for (int j = 0; j < 16; j++) begin
                rx_in = (j < false_len) ? 1'b0 : 1'b1;
                next_tick();
            end
        end else begin
            for (int k = 0; k < 10; k++) begin
                logic v;
                v = (k == 0) ? 1'b0 : ((k == 9) ? s : b[k-1]);
                if (k == drop_at) rx_enable = 1'b0;
                for (int j = 0; j < 16; j++) begin
                    rx_in = v ^ (noisy && (j == 8));
                    next_tick();
                end
            end
        end
        rx_in = 1'b1;
        repeat (4) next_tick();
    endtask

    // monitor / scoreboard
    initial begin
        wait (mon_on);
        forever begin
            @(negedge clk);
            if (clr_pend) begin
                done_clr = 1'b0;
                clr_pend = 1'b0;
                check(rx_done == 1'b0, "R9", "done after clear", rx_done, 0);
            end else if (rx_done && !prev_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R5", "unexpected done", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    check(rx_byte == cur.b, cur.tag, "byte (R6)", rx_byte, cur.b);
                    check(rx_stop == cur.s, cur.tag, "stop bit (R7)", rx_stop, cur.s);
                    check((cyc - start_cyc) == LATENCY, cur.tag, "latency (R8)",
                          int'(cyc - start_cyc), LATENCY);
                    if (auto_clr) begin
                        done_clr = 1'b1;
                        clr_pend = 1'b1;
                    end
                end
            end
            prev_done = rx_done;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(rx_done == 1'b0, "R1", "reset done", rx_done, 0);
        check(rx_byte == 8'h00, "R1", "reset byte", rx_byte, 0);
        check(rx_stop == 1'b0, "R1", "reset stop", rx_stop, 0);
        rst = 1'b0;
        mon_on = 1'b1;
        repeat (8) next_tick();

        // R2, R6, R7: clean frames
        send(8'h55, 1'b1, 1'b0, 1'b1, "R6", -1, 0);
        send(8'hA5, 1'b1, 1'b0, 1'b1, "R6", -1, 0);
        send(8'h00, 1'b1, 1'b0, 1'b1, "R2", -1, 0);
        send(8'hFF, 1'b1, 1'b0, 1'b1, "R6", -1, 0);
        send(8'h01, 1'b0, 1'b0, 1'b1, "R7", -1, 0);
        send(8'h80, 1'b1, 1'b0, 1'b1, "R7", -1, 0);

        // R4: one corrupted sample per bit
        send(8'h3C, 1'b1, 1'b1, 1'b1, "R4", -1, 0);
        send(8'hE1, 1'b0, 1'b1, 1'b1, "R4", -1, 0);

        // R5: noise start, then a real frame
        send(8'h00, 1'b1, 1'b0, 1'b0, "R5", -1, 6);
        repeat (700) @(negedge clk);
        check(rx_done == 1'b0, "R5", "done after false start", rx_done, 0);
        send(8'h96, 1'b1, 1'b0, 1'b1, "R5", -1, 0);

        // R3: receive disabled while idle
        rx_enable = 1'b0;
        send(8'h77, 1'b1, 1'b0, 1'b0, "R3", -1, 0);
        repeat (100) @(negedge clk);
        check(rx_done == 1'b0, "R3", "done while disabled", rx_done, 0);
        check(rx_byte == 8'h96, "R3", "byte while disabled", rx_byte, 8'h96);
        rx_enable = 1'b1;
        repeat (4) next_tick();

        // R10: disable mid-frame
        send(8'hC3, 1'b1, 1'b0, 1'b1, "R10", 3, 0);
        rx_enable = 1'b1;
        repeat (4) next_tick();

        // R9: flag holds until cleared
        auto_clr = 1'b0;
        send(8'h5A, 1'b1, 1'b0, 1'b1, "R9", -1, 0);
        repeat (100) @(negedge clk);
        check(rx_done == 1'b1, "R9", "done held", rx_done, 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(rx_done == 1'b0, "R9", "done after manual clear", rx_done, 0);
        auto_clr = 1'b1;

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8", "frames outstanding", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule